// File: doc/BRIEF.md
# PLL Clock Mode and Quality Monitor

This block selects and supervises the system clock source around a PLL. It runs entirely on an independent monitor clock. The crystal clock, the PLL output clock and the raw PLL lock indication are sampled as data, synchronized, and watched. Software chooses one of three operating modes: PLL powered off, bypass with the PLL running, or normal PLL operation. Software also returns the system clock to the PLL output with an explicit request. The block never makes that move on its own.

A clock is declared failed when no transition of it has been seen for a programmable number of monitor cycles. The lock indication is debounced before it is trusted. Once lock has been reached and is later lost, that is a loss-of-lock event. Every event (loss of lock, crystal failure, PLL clock failure) sets a sticky status bit. Software chooses, per event, whether the event raises the interrupt or requests a system reset. A failing PLL clock moves the selection back to the crystal. A failing crystal while the crystal is selected moves the selection to the self-clocked source, and only a reset leaves that source.

Top module: `clk_supervisor`

## Requirements
- R1: While `rst` is high, and in the first cycle after it, outputs read as follows: `mode_o` = 1 (bypass, PLL running), `clk_sel_o` = 0 (crystal), `pll_pwr_o` = 1, `lock_o` = 0, `status_o` = 0, `irq_o` = 0, `rst_req_o` = 0.
- R2: A cycle with `cfg_we_i` high loads `cfg_mode_i` into the mode on the next edge. Mode codes are 0 = PLL off, 1 = bypass with PLL running, 2 = normal PLL. A write of code 3 leaves the mode unchanged. `pll_pwr_o` is high in every mode except 0.
- R3: `lock_o` rises once the synchronized lock input (two monitor-clock stages) has been high on 16 consecutive edges while the PLL is powered. It falls on the edge after the synchronized input is seen low.
- R4: A fall of `lock_o` while the PLL is powered is a loss-of-lock event and sets `status_o[0]`. If `lol_rst_en_i` is high, the event also gives a one-cycle `rst_req_o` pulse. Switching the PLL off produces no such event.
- R5: A monitored clock is failed while no transition of it has been seen for at least `cfg_window_i` monitor cycles. A new failure event occurs on each entry into the failed state. The PLL clock is monitored only while the PLL is powered.
- R6: A crystal failure event sets `status_o[1]` and, with `xf_rst_en_i` high, pulses `rst_req_o`. If the crystal is selected at that moment, `clk_sel_o` becomes 2 (self-clocked).
- R7: A PLL clock failure event sets `status_o[2]`. If the PLL is selected, then with `pf_rst_en_i` low `clk_sel_o` returns to 0. With `pf_rst_en_i` high, `rst_req_o` pulses instead and the selection stays.
- R8: `clk_sel_o` becomes 1 only on the edge after a cycle in which all of the following hold: `relock_i` is high, `lock_o` is high, the mode is 2, the PLL clock is not failed, and the selection is not 2. Otherwise the request has no effect.
- R9: Writing mode 0 or 1 while the PLL is selected returns `clk_sel_o` to 0 on the same edge as the mode change.
- R10: `irq_o` is high while any status bit is set whose reset-enable input (`lol_rst_en_i`, `xf_rst_en_i`, `pf_rst_en_i` for bits 0, 1, 2) is low.
- R11: Status bits stay set until a cycle with the matching `clr_i` bit high clears them on the next edge.
- R12: Once `clk_sel_o` is 2, it stays 2 until reset; mode writes and relock requests do not change it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Monitor clock; all state runs on it |
| rst | input | 1 | Synchronous active-high reset |
| xtal_clk_i | input | 1 | Crystal clock, sampled as data |
| pll_clk_i | input | 1 | PLL output clock, sampled as data |
| pll_lock_raw_i | input | 1 | Raw lock indication from the PLL |
| cfg_we_i | input | 1 | Mode write strobe |
| cfg_mode_i | input | 2 | Mode code to write |
| cfg_window_i | input | WIN_W | Failure window in monitor cycles |
| lol_rst_en_i | input | 1 | Loss of lock requests reset instead of interrupt |
| xf_rst_en_i | input | 1 | Crystal failure requests reset instead of interrupt |
| pf_rst_en_i | input | 1 | PLL clock failure requests reset instead of fallback and interrupt |
| relock_i | input | 1 | Request to select the PLL output |
| clr_i | input | 3 | Write-one-to-clear for the status bits |
| clk_sel_o | output | 2 | Selected source: 0 crystal, 1 PLL, 2 self-clocked |
| mode_o | output | 2 | Current mode code |
| pll_pwr_o | output | 1 | PLL power enable |
| lock_o | output | 1 | Debounced lock flag |
| status_o | output | 3 | Sticky flags: bit0 loss of lock, bit1 crystal failure, bit2 PLL clock failure |
| irq_o | output | 1 | Interrupt request |
| rst_req_o | output | 1 | One-cycle system reset request |

## Verification
The hardest states to reach from the ports are the ones that need a history: a PLL clock failure while the PLL is selected, and a crystal failure while the crystal is selected. The PLL case needs a debounced lock, a mode write and an accepted relock request before the PLL clock is stopped. The crystal case moves the selection into the self-clocked state, which nothing but reset leaves. The stimulus therefore runs one long scripted history. It first reaches lock and selects the PLL, then exercises loss of lock with both actions and stops the PLL clock under both actions. It tries a relock while lock is down, powers the PLL off and checks that no events appear, and only then stops the crystal and probes the self-clocked state with mode writes and relock requests.

// File: rtl/clksup_pkg.sv
package clksup_pkg;

    typedef enum logic [1:0] {
        MODE_OFF = 2'd0,
        MODE_BYP = 2'd1,
        MODE_PLL = 2'd2
    } mode_e;

    typedef enum logic [1:0] {
        SRC_XTAL = 2'd0,
        SRC_PLL  = 2'd1,
        SRC_SCM  = 2'd2
    } src_e;

    typedef struct packed {
        logic pll_fail;
        logic xtal_fail;
        logic lol;
    } evt_t;

    function automatic logic mode_code_ok(logic [1:0] code);
        return code != 2'd3;
    endfunction

    function automatic logic mode_is_bypass(logic [1:0] code);
        return (code == MODE_OFF) || (code == MODE_BYP);
    endfunction

endpackage

// File: rtl/clksup_sync.sv
module clksup_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d_i,
    output logic lvl_o
);
    logic [STAGES-1:0] sh_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q <= '0;
        end else begin
            sh_q <= {sh_q[STAGES-2:0], d_i};
        end
    end

    assign lvl_o = sh_q[STAGES-1];
endmodule

// File: rtl/clksup_watch.sv
module clksup_watch #(
    parameter int WIN_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en_i,
    input  logic             lvl_i,
    input  logic [WIN_W-1:0] win_i,
    output logic             dead_o,
    output logic             fail_o
);
    logic [WIN_W-1:0] quiet_q;
    logic             prev_q;
    logic             dead_q;
    logic             toggled;

    assign toggled = lvl_i ^ prev_q;
    assign dead_o  = en_i && (quiet_q >= win_i);
    assign fail_o  = dead_o && !dead_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            quiet_q <= '0;
            prev_q  <= 1'b0;
            dead_q  <= 1'b0;
        end else begin
            prev_q <= lvl_i;
            dead_q <= dead_o;
            if (!en_i || toggled) begin
                quiet_q <= '0;
            end else if (quiet_q != '1) begin
                quiet_q <= quiet_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/clksup_lock.sv
module clksup_lock #(
    parameter int LOCK_CYCLES = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic en_i,
    input  logic lvl_i,
    output logic lock_o,
    output logic lol_o
);
    localparam int CW = $clog2(LOCK_CYCLES + 1);
    localparam logic [CW-1:0] FULL = CW'(LOCK_CYCLES);

    logic [CW-1:0] run_q;
    logic          lock_q;

    assign lock_o = (run_q == FULL);
    assign lol_o  = en_i && lock_q && !lock_o;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q  <= '0;
            lock_q <= 1'b0;
        end else begin
            lock_q <= lock_o;
            if (!en_i || !lvl_i) begin
                run_q <= '0;
            end else if (!lock_o) begin
                run_q <= run_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/clk_supervisor.sv
module clk_supervisor
    import clksup_pkg::*;
#(
    parameter int WIN_W       = 12,
    parameter int SYNC_STAGES = 2,
    parameter int LOCK_CYCLES = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             xtal_clk_i,
    input  logic             pll_clk_i,
    input  logic             pll_lock_raw_i,
    input  logic             cfg_we_i,
    input  logic [1:0]       cfg_mode_i,
    input  logic [WIN_W-1:0] cfg_window_i,
    input  logic             lol_rst_en_i,
    input  logic             xf_rst_en_i,
    input  logic             pf_rst_en_i,
    input  logic             relock_i,
    input  logic [2:0]       clr_i,
    output logic [1:0]       clk_sel_o,
    output logic [1:0]       mode_o,
    output logic             pll_pwr_o,
    output logic             lock_o,
    output logic [2:0]       status_o,
    output logic             irq_o,
    output logic             rst_req_o
);
    mode_e mode_q;
    src_e  src_q, src_nxt;
    evt_t  flags_q, evt, rst_cfg;
    logic  rreq_q;
    logic  pwr;
    logic  x_lvl, p_lvl, l_lvl;
    logic  x_dead, p_dead;
    logic  lock, mode_wr;

    assign pwr     = (mode_q != MODE_OFF);
    assign mode_wr = cfg_we_i && mode_code_ok(cfg_mode_i);
    assign rst_cfg = evt_t'({pf_rst_en_i, xf_rst_en_i, lol_rst_en_i});

    clksup_sync #(.STAGES(SYNC_STAGES)) u_sync_x (
        .clk(clk), .rst(rst), .d_i(xtal_clk_i), .lvl_o(x_lvl));
    clksup_sync #(.STAGES(SYNC_STAGES)) u_sync_p (
        .clk(clk), .rst(rst), .d_i(pll_clk_i), .lvl_o(p_lvl));
    clksup_sync #(.STAGES(SYNC_STAGES)) u_sync_l (
        .clk(clk), .rst(rst), .d_i(pll_lock_raw_i), .lvl_o(l_lvl));

    clksup_watch #(.WIN_W(WIN_W)) u_watch_x (
        .clk(clk), .rst(rst), .en_i(1'b1), .lvl_i(x_lvl),
        .win_i(cfg_window_i), .dead_o(x_dead), .fail_o(evt.xtal_fail));
    clksup_watch #(.WIN_W(WIN_W)) u_watch_p (
        .clk(clk), .rst(rst), .en_i(pwr), .lvl_i(p_lvl),
        .win_i(cfg_window_i), .dead_o(p_dead), .fail_o(evt.pll_fail));

    clksup_lock #(.LOCK_CYCLES(LOCK_CYCLES)) u_lock (
        .clk(clk), .rst(rst), .en_i(pwr), .lvl_i(l_lvl),
        .lock_o(lock), .lol_o(evt.lol));

    // Source selection, highest priority first
    always_comb begin
        src_nxt = src_q;
        if (evt.xtal_fail && src_q == SRC_XTAL) begin
            src_nxt = SRC_SCM;
        end else if (evt.pll_fail && src_q == SRC_PLL && !pf_rst_en_i) begin
            src_nxt = SRC_XTAL;
        end else if (src_q == SRC_PLL && mode_wr && mode_is_bypass(cfg_mode_i)) begin
            src_nxt = SRC_XTAL;
        end else if (relock_i && lock && mode_q == MODE_PLL &&
                     src_q != SRC_SCM && !p_dead) begin
            src_nxt = SRC_PLL;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q  <= MODE_BYP;
            src_q   <= SRC_XTAL;
            flags_q <= '0;
            rreq_q  <= 1'b0;
        end else begin
            if (mode_wr) begin
                mode_q <= mode_e'(cfg_mode_i);
            end
            src_q   <= src_nxt;
            flags_q <= evt_t'((flags_q & ~evt_t'(clr_i)) | evt);
            rreq_q  <= |(evt & rst_cfg);
        end
    end

    // x_dead is consumed through the failure event only
    logic unused_x;
    assign unused_x = x_dead;

    assign clk_sel_o = src_q;
    assign mode_o    = mode_q;
    assign pll_pwr_o = pwr;
    assign lock_o    = lock;
    assign status_o  = flags_q;
    assign irq_o     = |(flags_q & ~rst_cfg) | (1'b0 & unused_x);
    assign rst_req_o = rreq_q;
endmodule

// File: rtl/clk_supervisor_chk.sv
module clk_supervisor_chk #(
    parameter int WIN_W = 12
) (
    input logic             clk,
    input logic             rst,
    input logic             cfg_we_i,
    input logic [1:0]       cfg_mode_i,
    input logic             relock_i,
    input logic [2:0]       clr_i,
    input logic [1:0]       clk_sel_o,
    input logic [1:0]       mode_o,
    input logic             lock_o,
    input logic [2:0]       status_o,
    input logic             irq_o,
    input logic             rst_req_o,
    input logic [WIN_W-1:0] cfg_window_i
);
    assert_reset_state_R1: assert property (@(posedge clk)
        rst |=> (clk_sel_o == 2'd0 && mode_o == 2'd1 && status_o == 3'd0 && !rst_req_o));

    assert_relock_gate_R8: assert property (@(posedge clk) disable iff (rst)
        (clk_sel_o == 2'd1 && $past(clk_sel_o) != 2'd1) |-> $past(relock_i && lock_o));

    assert_bypass_drop_R9: assert property (@(posedge clk) disable iff (rst)
        $past(cfg_we_i && cfg_mode_i < 2'd2) |-> clk_sel_o != 2'd1);

    assert_irq_source_R10: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> status_o != 3'd0);

    assert_sticky_R11: assert property (@(posedge clk) disable iff (rst)
        (($past(status_o & ~clr_i) & ~status_o) == 3'd0));

    assert_scm_hold_R12: assert property (@(posedge clk) disable iff (rst)
        $past(clk_sel_o) == 2'd2 |-> clk_sel_o == 2'd2);

    logic unused_c;
    assign unused_c = ^cfg_window_i;
endmodule

bind clk_supervisor clk_supervisor_chk #(.WIN_W(WIN_W)) u_chk (
    .clk(clk), .rst(rst), .cfg_we_i(cfg_we_i), .cfg_mode_i(cfg_mode_i),
    .relock_i(relock_i), .clr_i(clr_i), .clk_sel_o(clk_sel_o), .mode_o(mode_o),
    .lock_o(lock_o), .status_o(status_o), .irq_o(irq_o), .rst_req_o(rst_req_o),
    .cfg_window_i(cfg_window_i));

// File: tb/clk_supervisor_test.sv
module clk_supervisor_test;
    localparam int W   = 12;
    localparam int WIN = 8;

    logic clk = 0, rst = 1;
    logic xtal_clk = 0, pll_clk = 0, lock_raw = 0;
    logic cfg_we = 0, relock = 0;
    logic [1:0] cfg_mode = 0;
    logic [W-1:0] cfg_window = W'(WIN);
    logic lol_rst = 0, xf_rst = 0, pf_rst = 0;
    logic [2:0] clr = 0;
    logic [1:0] clk_sel, mode;
    logic pll_pwr, lock, irq, rst_req;
    logic [2:0] status;

    clk_supervisor uut (
        .clk(clk), .rst(rst), .xtal_clk_i(xtal_clk), .pll_clk_i(pll_clk),
        .pll_lock_raw_i(lock_raw), .cfg_we_i(cfg_we), .cfg_mode_i(cfg_mode),
        .cfg_window_i(cfg_window), .lol_rst_en_i(lol_rst), .xf_rst_en_i(xf_rst),
        .pf_rst_en_i(pf_rst), .relock_i(relock), .clr_i(clr),
        .clk_sel_o(clk_sel), .mode_o(mode), .pll_pwr_o(pll_pwr), .lock_o(lock),
        .status_o(status), .irq_o(irq), .rst_req_o(rst_req));

    always #4 clk = ~clk;

    int compared = 0, mismatched = 0, cycles = 0;
    bit started = 0, done = 0;
    string cur_req = "R1";
    bit x_run = 1, p_run = 1;

    // behavioural reference state
    int m_x[3], m_p[3], m_l[2];
    int m_xq, m_pq, m_xd, m_pd, m_run, m_lq;
    int m_mode, m_src, m_flags, m_rreq;

    always @(posedge clk) begin
        #2;
        if (x_run) xtal_clk = ~xtal_clk;
        if (p_run) pll_clk = ~pll_clk;
    end

    always @(posedge clk) begin
        int pwr, xe, pe, xdead, pdead, xf, pf, lk, lol;
        started = 1;
        if (rst) begin
            m_x = '{0, 0, 0}; m_p = '{0, 0, 0}; m_l = '{0, 0};
            m_xq = 0; m_pq = 0; m_xd = 0; m_pd = 0; m_run = 0; m_lq = 0;
            m_mode = 1; m_src = 0; m_flags = 0; m_rreq = 0;
        end else begin
            pwr   = (m_mode != 0);
            xe    = (m_x[1] != m_x[2]);
            pe    = (m_p[1] != m_p[2]);
            xdead = (m_xq >= WIN);
            pdead = pwr && (m_pq >= WIN);
            xf    = xdead && !m_xd;
            pf    = pdead && !m_pd;
            lk    = (m_run == 16);
            lol   = pwr && m_lq && !lk;
            if (xf && m_src == 0) m_src = 2;
            else if (pf && m_src == 1 && !pf_rst) m_src = 0;
            else if (m_src == 1 && cfg_we && cfg_mode < 2) m_src = 0;
            else if (relock && lk && m_mode == 2 && m_src != 2 && !pdead) m_src = 1;
            if (cfg_we && cfg_mode != 3) m_mode = cfg_mode;
            m_rreq  = (lol && lol_rst) || (xf && xf_rst) || (pf && pf_rst);
            m_flags = (m_flags & ~int'(clr)) | (pf * 4) | (xf * 2) | lol;
            m_xq = xe ? 0 : ((m_xq < 4095) ? m_xq + 1 : m_xq);
            m_pq = (!pwr || pe) ? 0 : ((m_pq < 4095) ? m_pq + 1 : m_pq);
            m_xd = xdead; m_pd = pdead;
            m_run = (!pwr || !m_l[1]) ? 0 : (lk ? m_run : m_run + 1);
            m_lq = lk;
            m_x[2] = m_x[1]; m_x[1] = m_x[0]; m_x[0] = xtal_clk;
            m_p[2] = m_p[1]; m_p[1] = m_p[0]; m_p[0] = pll_clk;
            m_l[1] = m_l[0]; m_l[0] = lock_raw;
        end
    end

    task automatic check(string nm, int act, int exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s %s: actual %0d expected %0d at cycle %0d",
                     cur_req, nm, act, exp, cycles);
        end
    endtask

    always @(negedge clk) begin
        if (started && !done) begin
            int exp_irq;
            exp_irq = ((m_flags & ~{29'd0, pf_rst, xf_rst, lol_rst}) != 0);
            check("clk_sel", clk_sel, m_src);
            check("mode", mode, m_mode);
            check("pll_pwr", pll_pwr, m_mode != 0);
            check("lock", lock, m_run == 16);
            check("status", status, m_flags);
            check("irq", irq, exp_irq);
            check("rst_req", rst_req, m_rreq);
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 50000 && !done) begin
            done = 1;
            mismatched++;
            $display("FAIL watchdog: actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    task automatic cyc(int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic write_mode(int m);
        cyc(1); cfg_we = 1; cfg_mode = 2'(m);
        cyc(1); cfg_we = 0;
    endtask

    task automatic req_relock();
        cyc(1); relock = 1;
        cyc(1); relock = 0;
    endtask

    task automatic clear(int b);
        cyc(1); clr = 3'(b);
        cyc(1); clr = 0;
    endtask

    initial begin
        cur_req = "R1"; cyc(4); rst = 0; cyc(3);
        cur_req = "R3"; lock_raw = 1; cyc(25);
        cur_req = "R8"; req_relock(); cyc(3);          // bypass mode: ignored
        cur_req = "R2"; write_mode(2); cyc(2);
        cur_req = "R8"; req_relock(); cyc(3);          // now selects PLL
        cur_req = "R4"; lock_raw = 0; cyc(4); lock_raw = 1; cyc(22);
        cur_req = "R11"; clear(1); cyc(3);
        cur_req = "R4"; lol_rst = 1; lock_raw = 0; cyc(4); lock_raw = 1; cyc(22);
        cur_req = "R10"; lol_rst = 0; cyc(2); lol_rst = 1;
        cur_req = "R11"; clear(1); cyc(2);
        cur_req = "R7"; p_run = 0; cyc(15); p_run = 1; cyc(5);
        cur_req = "R8"; lock_raw = 0; cyc(5); req_relock(); cyc(3);
        lock_raw = 1; cyc(22); req_relock(); cyc(3);
        cur_req = "R11"; clear(7); cyc(2);
        cur_req = "R7"; pf_rst = 1; p_run = 0; cyc(15); p_run = 1; cyc(5); clear(4);
        cur_req = "R9"; write_mode(1); cyc(3);
        cur_req = "R2"; write_mode(3); cyc(3);
        cur_req = "R5"; write_mode(0); lock_raw = 0; p_run = 0; cyc(20);
        write_mode(1); p_run = 1; lock_raw = 1; cyc(25);
        cur_req = "R6"; x_run = 0; cyc(15); x_run = 1; cyc(4);
        cur_req = "R12"; write_mode(2); req_relock(); cyc(3); write_mode(1); cyc(3);
        cur_req = "R10"; xf_rst = 1; cyc(2);
        cur_req = "R11"; clear(2); cyc(2);
        cur_req = "R6"; x_run = 0; cyc(15); x_run = 1; cyc(4);
        cur_req = "R1"; rst = 1; cyc(3); rst = 0; cyc(3);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule